// File: doc/BRIEF.md
# Signed/Unsigned Fractional 8x8 Multiplier

This block multiplies two 8-bit operands into a 16-bit product. Each operand is read as either unsigned or two's complement, according to a mode code. The product can be returned in integer form or in fractional form. Fractional form treats the operands as 1.7 fixed-point values and shifts the product left by one bit. Alongside the product the block reports a carry flag and a zero flag. No other flag is produced.

A caller presents both operands and a mode together with a one-cycle start pulse. Two clock edges later the product appears as a high byte and a low byte, with the flags and a one-cycle done strobe. A multiply in flight occupies the unit for both of those cycles. A start pulse that arrives during either of them is dropped. The outputs keep their values until the next done strobe. The block does not write the result into a register pair.

Top module: `frac_mul8`

## Requirements
- R1: With mode_i[1:0] = 00, both operands are unsigned, and {prod_hi_o, prod_lo_o} is the low 16 bits of opa_i × opb_i.
- R2: With mode_i[1:0] = 01, both operands are two's complement, and the 16-bit result is the signed product.
- R3: With mode_i[1:0] = 10, opa_i is two's complement and opb_i is unsigned, and the result is their product.
- R4: With mode_i[2] = 1 (fractional), the result is the integer product shifted left by one bit and truncated to 16 bits. Bit 0 is zero. prod_hi_o carries bits 15:8 and prod_lo_o carries bits 7:0.
- R5: carry_o equals bit 15 of the integer product, taken before any fractional shift.
- R6: zero_o is 1 exactly when the final 16-bit result, after any shift, is zero.
- R7: A start accepted at clock edge k raises done_o after edge k+1, for exactly one cycle. The product and flags of that start are valid in the same cycle.
- R8: A start_i pulse sampled on the edge after an accepted start, or while done_o is high, is ignored. It produces no done strobe and does not change the outputs.
- R9: Product and flags hold their values between done strobes. Reset clears the product, both flags and done_o to zero.
- R10: mode_i[1:0] = 11 behaves exactly like 00, with both operands unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; operands and mode are sampled with it |
| mode_i | input | 3 | Bit 2 selects fractional form; bits 1:0 select signedness (00 uu, 01 ss, 10 su, 11 uu) |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| prod_hi_o | output | 8 | Result bits 15:8 |
| prod_lo_o | output | 8 | Result bits 7:0 |
| carry_o | output | 1 | Bit 15 of the product before the fractional shift |
| zero_o | output | 1 | Final result is zero |
| done_o | output | 1 | One-cycle strobe marking a valid result |

## Verification
A wrong operand extension, for example sign-extending an unsigned second operand, shows up as a wrong high byte on the very done strobe of the affected multiply. It only shows when the operand has its top bit set, so the sweeps run every first-operand value against operands such as 0x80 and 0xFF in every mode. A wrong stage-valid or busy state shows up at the ports in one of two ways. Either done_o fires one cycle early or late, or it fires a second time after an ignored start. The bench looks at done_o on every cycle around a multiply, so such faults are seen within two cycles.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  typedef enum logic [1:0] {
    KIND_UU  = 2'b00,
    KIND_SS  = 2'b01,
    KIND_SU  = 2'b10,
    KIND_UU2 = 2'b11
  } kind_e;

  function automatic logic sign_a(input kind_e k);
    return (k == KIND_SS) || (k == KIND_SU);
  endfunction

  function automatic logic sign_b(input kind_e k);
    return (k == KIND_SS);
  endfunction
endpackage

// File: rtl/fmul_ext.sv
module fmul_ext #(
  parameter int W = 8
) (
  input  logic [W-1:0] d_i,
  input  logic         sgn_i,
  output logic [W:0]   x_o
);
  assign x_o = {sgn_i & d_i[W-1], d_i};
endmodule

// File: rtl/fmul_stage.sv
module fmul_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         accept_i,
  input  logic [W:0]   xa_i,
  input  logic [W:0]   xb_i,
  input  logic         frac_i,
  output logic [W:0]   xa_o,
  output logic [W:0]   xb_o,
  output logic         frac_o,
  output logic         vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xa_o   <= '0;
      xb_o   <= '0;
      frac_o <= 1'b0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= accept_i;
      if (accept_i) begin
        xa_o   <= xa_i;
        xb_o   <= xb_i;
        frac_o <= frac_i;
      end
    end
  end
endmodule

// File: rtl/fmul_out.sv
module fmul_out #(
  parameter int W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            vld_i,
  input  logic [W:0]      xa_i,
  input  logic [W:0]      xb_i,
  input  logic            frac_i,
  output logic [2*W-1:0]  res_o,
  output logic            carry_o,
  output logic            zero_o,
  output logic            done_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] raw;
  logic [PW-1:0] res_d;

  // low PW bits of a signed product do not depend on the wider upper part
  assign raw   = PW'($signed(xa_i)) * PW'($signed(xb_i));
  assign res_d = frac_i ? {raw[PW-2:0], 1'b0} : raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      carry_o <= 1'b0;
      zero_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= vld_i;
      if (vld_i) begin
        res_o   <= res_d;
        carry_o <= raw[PW-1];
        zero_o  <= (res_d == '0);
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> ($stable(res_o) && $stable(carry_o) && $stable(zero_o)));
  // R6
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (zero_o == (res_o == '0)));
  // R4
  frac_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && frac_i) |=> (res_o[0] == 1'b0));
endmodule

// File: rtl/frac_mul8.sv
module frac_mul8 #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [2:0]   mode_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic [W-1:0] prod_hi_o,
  output logic [W-1:0] prod_lo_o,
  output logic         carry_o,
  output logic         zero_o,
  output logic         done_o
);
  import fmul_pkg::*;

  localparam int PW = 2 * W;

  kind_e          kind;
  logic [W-1:0]   op_in  [2];
  logic [1:0]     sgn_in;
  logic [W:0]     x_ext  [2];
  logic [W:0]     xa_q, xb_q;
  logic           frac_q, vld_q;
  logic           busy, accept;
  logic [PW-1:0]  res;

  assign kind      = kind_e'(mode_i[1:0]);
  assign op_in[0]  = opa_i;
  assign op_in[1]  = opb_i;
  assign sgn_in[0] = sign_a(kind);
  assign sgn_in[1] = sign_b(kind);

  for (genvar i = 0; i < 2; i++) begin : g_ext
    fmul_ext #(.W(W)) u_ext (
      .d_i  (op_in[i]),
      .sgn_i(sgn_in[i]),
      .x_o  (x_ext[i])
    );
  end

  // in progress: the stage cycle and the done cycle
  assign busy   = vld_q | done_o;
  assign accept = start_i & ~busy;

  fmul_stage #(.W(W)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .xa_i    (x_ext[0]),
    .xb_i    (x_ext[1]),
    .frac_i  (mode_i[2]),
    .xa_o    (xa_q),
    .xb_o    (xb_q),
    .frac_o  (frac_q),
    .vld_o   (vld_q)
  );

  fmul_out #(.W(W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (vld_q),
    .xa_i   (xa_q),
    .xb_i   (xb_q),
    .frac_i (frac_q),
    .res_o  (res),
    .carry_o(carry_o),
    .zero_o (zero_o),
    .done_o (done_o)
  );

  assign prod_hi_o = res[PW-1:W];
  assign prod_lo_o = res[W-1:0];

  // R7
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ##1 done_o);
  // R8
  ignore_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy) |=> ##1 !done_o);
  // R8
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q);
  // R3
  su_opb_unsigned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && kind == KIND_SU) |=> (xb_q[W] == 1'b0));
endmodule

// File: tb/tb_frac_mul8.sv
module tb_frac_mul8;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] mode_i = '0;
  logic [7:0] opa_i = '0, opb_i = '0;
  logic [7:0] prod_hi_o, prod_lo_o;
  logic       carry_o, zero_o, done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  frac_mul8 #(.W(8)) dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected below 150000", cycles);
      report();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] m);
    if (m[2]) return "R4";
    case (m[1:0])
      2'b01:   return "R2";
      2'b10:   return "R3";
      2'b11:   return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic model(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b,
                       output logic [15:0] r, output logic c, output logic z);
    int av, bv, p;
    logic [15:0] raw;
    av  = (m[1:0] == 2'b01 || m[1:0] == 2'b10) ? int'($signed(a)) : int'(a);
    bv  = (m[1:0] == 2'b01) ? int'($signed(b)) : int'(b);
    p   = av * bv;
    raw = p[15:0];
    c   = raw[15];
    r   = m[2] ? {raw[14:0], 1'b0} : raw;
    z   = (r == 16'h0000);
  endtask

  // one multiply: start at edge k, result checked after edge k+1, idle cycle after
  task automatic run(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
    logic [15:0] r;
    logic c, z;
    model(m, a, b, r, c, z);
    start_i = 1'b1; mode_i = m; opa_i = a; opb_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R7 early done", done_o, 0);
    @(negedge clk_i);
    chk("R7 done", done_o, 1);
    chk(req_of(m), {prod_hi_o, prod_lo_o}, r);
    chk("R5 carry", carry_o, c);
    chk("R6 zero", zero_o, z);
    @(negedge clk_i);
    chk("R7 single pulse", done_o, 0);
  endtask

  logic [7:0] corner [10] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81,
                              8'hFF, 8'h40, 8'hC0, 8'h55, 8'hAA};

  initial begin
    logic [15:0] r1;
    logic c1, z1;
    @(negedge clk_i);
    @(negedge clk_i);
    // R9 reset state
    chk("R9 reset prod", {prod_hi_o, prod_lo_o}, 0);
    chk("R9 reset flags", {carry_o, zero_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // named corners: R2 0x80*0x80, R1 0xFF*0xFF, zero
    run(3'b001, 8'h80, 8'h80);
    chk("R2 0x80x0x80", {prod_hi_o, prod_lo_o}, 16'h4000);
    run(3'b101, 8'h80, 8'h80);
    chk("R4 frac 0x80x0x80", {prod_hi_o, prod_lo_o, 7'b0, carry_o}, {16'h8000, 8'h00});
    run(3'b000, 8'hFF, 8'hFF);
    chk("R1 0xFFx0xFF", {prod_hi_o, prod_lo_o}, 16'hFE01);
    run(3'b010, 8'hFF, 8'hFF);
    chk("R3 -1x255", {prod_hi_o, prod_lo_o}, 16'hFF01);
    run(3'b000, 8'h00, 8'h5A);
    chk("R6 zero set", zero_o, 1);

    // sweep: every opa against corner opb in every mode code
    for (int m = 0; m < 8; m++)
      for (int a = 0; a < 256; a++)
        for (int j = 0; j < 10; j++)
          run(3'(m), 8'(a), corner[j]);

    // R8: starts while busy are dropped
    model(3'b001, 8'h12, 8'h34, r1, c1, z1);
    start_i = 1'b1; mode_i = 3'b001; opa_i = 8'h12; opb_i = 8'h34;
    @(negedge clk_i);
    opa_i = 8'h77; opb_i = 8'h99;       // start held during stage cycle
    @(negedge clk_i);
    chk("R8 result of first start", {prod_hi_o, prod_lo_o}, r1);
    chk("R7 done with busy start", done_o, 1);
    opa_i = 8'hF0; opb_i = 8'h0F;       // start held during done cycle
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R8 no second done", done_o, 0);
    @(negedge clk_i);
    chk("R8 no late done", done_o, 0);
    chk("R8 R9 outputs held", {prod_hi_o, prod_lo_o}, r1);
    @(negedge clk_i);
    chk("R9 still held", {prod_hi_o, prod_lo_o, 6'b0, carry_o, zero_o}, {r1, 6'b0, c1, z1});

    report();
  end
endmodule